// File: doc/BRIEF.md
# Debounced Edge Interrupt Detector

This block watches six slow input lines (a power button, three keys, an AC-present line and an external reset input) for level changes. Each line can report a high-to-low change, a low-to-high change, or both. A change is reported only after the new level has held steady for a programmable debounce period. Short glitches are discarded.

Each reported change sets a sticky cause bit for its line and direction. All cause bits are ORed into one interrupt line. Software reads the cause vectors and clears individual bits by writing ones to the clear inputs.

All inputs are assumed to be synchronous to `clk` already. Register decode sits outside the block.

Top module: `edge_irq_debounce`

## Requirements
- R1: While `rst_n` is low and directly after it rises, both cause vectors are zero and `irq_o` is low. On the first clock edge after reset the current line levels are taken as the reference, and nothing is reported for them.
- R2: Bit positions in `line_i` and in both cause vectors are fixed: bit 0 is the power button, bits 1 to 3 are key0 to key2, bit 4 is AC present and bit 5 is the external reset input.
- R3: A line that differs from its reference level counts as changed once the new level is sampled on `debounce_i`+1 consecutive rising clock edges. The cause bit is visible just after the last of those edges. A value of 0 in `debounce_i` qualifies a change on the first edge.
- R4: If the line returns to its reference level before the change qualifies, the pending count is dropped and nothing is reported. The reference stays unchanged. A later change starts counting from zero.
- R5: `fall_en_i[i]` enables reporting of a qualified high-to-low change on line i, and `rise_en_i[i]` enables reporting of a qualified low-to-high change. A qualified change in a disabled direction sets no bit, but it still moves the reference to the new level.
- R6: A cause bit stays set while its clear bit is zero, whatever the line does afterwards.
- R7: A one in `clr_fall_i[i]` or `clr_rise_i[i]` clears only that bit on the next edge. If a new qualified change for the same bit lands on that same edge, the bit ends up set.
- R8: `irq_o` is high exactly when at least one bit of either cause vector is set.
- R9: Every line has its own debounce counter. A pending or cancelled change on one line does not delay or suppress a change on another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | NUM_LINES | Monitored line levels |
| fall_en_i | input | NUM_LINES | High-to-low report enables |
| rise_en_i | input | NUM_LINES | Low-to-high report enables |
| debounce_i | input | CNT_W | Debounce length (stable edges minus one) |
| clr_fall_i | input | NUM_LINES | Write-one-to-clear for high-to-low causes |
| clr_rise_i | input | NUM_LINES | Write-one-to-clear for low-to-high causes |
| fall_sts_o | output | NUM_LINES | Sticky high-to-low cause bits |
| rise_sts_o | output | NUM_LINES | Sticky low-to-high cause bits |
| irq_o | output | 1 | Consolidated interrupt |

## Verification
The bench builds the block with NUM_LINES=6 and a narrow CNT_W=4. This keeps the largest debounce setting (15) within a few dozen cycles, so the upper boundary can be exercised alongside the zero setting. A debounce of 3 is used for the vector table, which puts the one-cycle-short glitch and the exact qualifying length side by side. Overlapping activity on two lines, a clear landing on the qualifying edge, and a change in a disabled direction followed by an enabled one are covered by directed sequences.

// File: rtl/edge_irq_debounce.sv
module edge_irq_debounce #(
  parameter int NUM_LINES = 6,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [NUM_LINES-1:0] fall_en_i,
  input  logic [NUM_LINES-1:0] rise_en_i,
  input  logic [CNT_W-1:0]     debounce_i,
  input  logic [NUM_LINES-1:0] clr_fall_i,
  input  logic [NUM_LINES-1:0] clr_rise_i,
  output logic [NUM_LINES-1:0] fall_sts_o,
  output logic [NUM_LINES-1:0] rise_sts_o,
  output logic                 irq_o
);

  logic                 primed_q;
  logic [NUM_LINES-1:0] ref_q;
  logic [NUM_LINES-1:0] qual;
  logic [NUM_LINES-1:0] fall_hit;
  logic [NUM_LINES-1:0] rise_hit;
  logic [CNT_W-1:0]     cnt_q [NUM_LINES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign qual[g] = primed_q && (line_i[g] != ref_q[g]) && (cnt_q[g] == debounce_i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q[g] <= 1'b0;
        cnt_q[g] <= '0;
      end else if (!primed_q) begin
        ref_q[g] <= line_i[g];
        cnt_q[g] <= '0;
      end else if (line_i[g] != ref_q[g]) begin
        if (qual[g]) begin
          ref_q[g] <= line_i[g];
          cnt_q[g] <= '0;
        end else begin
          cnt_q[g] <= cnt_q[g] + 1'b1;
        end
      end else begin
        cnt_q[g] <= '0;
      end
    end
  end

  assign fall_hit = qual &  ref_q & fall_en_i;
  assign rise_hit = qual & ~ref_q & rise_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_sts_o <= '0;
      rise_sts_o <= '0;
    end else begin
      fall_sts_o <= (fall_sts_o & ~clr_fall_i) | fall_hit;
      rise_sts_o <= (rise_sts_o & ~clr_rise_i) | rise_hit;
    end
  end

  assign irq_o = |{fall_sts_o, rise_sts_o};

endmodule

module edge_irq_debounce_chk #(
  parameter int NUM_LINES = 6,
  parameter int CNT_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] line_i,
  input logic [NUM_LINES-1:0] fall_en_i,
  input logic [NUM_LINES-1:0] rise_en_i,
  input logic [CNT_W-1:0]     debounce_i,
  input logic [NUM_LINES-1:0] clr_fall_i,
  input logic [NUM_LINES-1:0] clr_rise_i,
  input logic [NUM_LINES-1:0] fall_sts_o,
  input logic [NUM_LINES-1:0] rise_sts_o,
  input logic                 irq_o
);

  // R6
  sticky_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(fall_sts_o) & ~$past(clr_fall_i) & ~fall_sts_o) == '0));

  // R6
  sticky_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rise_sts_o) & ~$past(clr_rise_i) & ~rise_sts_o) == '0));

  // R5
  fall_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall_sts_o & ~$past(fall_sts_o) & ~$past(fall_en_i)) == '0));

  // R5
  rise_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_sts_o & ~$past(rise_sts_o) & ~$past(rise_en_i)) == '0));

  // R3
  fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fall_sts_o & ~$past(fall_sts_o) & $past(line_i)) == '0));

  // R3
  rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_sts_o & ~$past(rise_sts_o) & ~$past(line_i)) == '0));

  // R3
  fall_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(debounce_i) != '0) |->
      ((fall_sts_o & ~$past(fall_sts_o) & $past(line_i, 2)) == '0));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (((fall_sts_o & ~$past(fall_sts_o)) | (rise_sts_o & ~$past(rise_sts_o))) != '0));

endmodule

bind edge_irq_debounce edge_irq_debounce_chk #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_i(line_i), .fall_en_i(fall_en_i), .rise_en_i(rise_en_i),
  .debounce_i(debounce_i), .clr_fall_i(clr_fall_i), .clr_rise_i(clr_rise_i),
  .fall_sts_o(fall_sts_o), .rise_sts_o(rise_sts_o), .irq_o(irq_o));

// File: tb/sim_edge_irq_debounce.sv
module sim_edge_irq_debounce;
  localparam int NL = 6;
  localparam int CW = 4;
  localparam int D  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] line_i = 6'b100001;
  logic [NL-1:0] fall_en_i = '1, rise_en_i = '1, clr_fall_i = '0, clr_rise_i = '0;
  logic [CW-1:0] debounce_i = CW'(D);
  logic [NL-1:0] fall_sts_o, rise_sts_o;
  logic irq_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  edge_irq_debounce #(.NUM_LINES(NL), .CNT_W(CW)) u0 (.*);

  // entry: idx[13:11] lvl[10] hold[9:5] fen[4] ren[3] expf[2] expr[1] unused[0]
  localparam int NT = 10;
  localparam logic [13:0] TBL [NT] = '{
    {3'd0, 1'b0, 5'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd0, 1'b1, 5'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {3'd2, 1'b1, 5'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd2, 1'b1, 5'd4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {3'd1, 1'b1, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd1, 1'b0, 5'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd4, 1'b1, 5'd4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {3'd5, 1'b0, 5'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd3, 1'b1, 5'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd3, 1'b1, 5'd4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_fall_i = '1; clr_rise_i = '1;
    tick(1);
    clr_fall_i = '0; clr_rise_i = '0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(2);
    check("R1 in reset status", {fall_sts_o, rise_sts_o, irq_o}, '0);
    rst_n = 1'b1;
    tick(5);
    check("R1 after reset no report", {fall_sts_o, rise_sts_o, irq_o}, '0);

    for (int e = 0; e < NT; e++) begin
      logic [2:0] idx; logic lvl; int hold;
      logic [NL-1:0] ef, er;
      idx = TBL[e][13:11]; lvl = TBL[e][10]; hold = int'(TBL[e][9:5]);
      fall_en_i = '0; rise_en_i = '0;
      fall_en_i[idx] = TBL[e][4]; rise_en_i[idx] = TBL[e][3];
      clear_all();
      line_i[idx] = lvl;
      tick(hold);
      ef = '0; er = '0; ef[idx] = TBL[e][2]; er[idx] = TBL[e][1];
      check($sformatf("R2 R3 R5 table %0d fall", e), fall_sts_o, ef);
      check($sformatf("R3 R5 table %0d rise", e), rise_sts_o, er);
      check($sformatf("R8 table %0d irq", e), irq_o, TBL[e][2] | TBL[e][1]);
      if (hold < D + 1) begin
        line_i[idx] = ~lvl;
        tick(D + 3);
        check($sformatf("R4 table %0d glitch dropped", e), {fall_sts_o, rise_sts_o}, '0);
      end
    end

    // R6: sticky while the line moves on, enables off
    fall_en_i = '1; rise_en_i = '0;
    clear_all();
    line_i[0] = 1'b0; tick(D + 1);
    fall_en_i = '0;
    line_i[0] = 1'b1; tick(D + 4);
    check("R6 sticky after line returns", fall_sts_o[0], 1'b1);
    check("R8 irq held", irq_o, 1'b1);

    // R7: clear targets one bit only
    fall_en_i = '1;
    line_i[1] = 1'b1; tick(D + 1);
    line_i[1] = 1'b0; tick(D + 1);
    check("R7 two bits set", fall_sts_o, 6'b000011);
    clr_fall_i = 6'b000010; tick(1); clr_fall_i = '0;
    check("R7 only targeted bit cleared", fall_sts_o, 6'b000001);

    // R7: set wins over clear on the same edge (line0 fall bit already set)
    line_i[0] = 1'b0; tick(D);
    clr_fall_i = 6'b000001; tick(1); clr_fall_i = '0;
    check("R7 set wins over clear", fall_sts_o[0], 1'b1);
    clr_fall_i = 6'b000001; tick(1); clr_fall_i = '0;
    check("R7 clear then irq low", {fall_sts_o, rise_sts_o, irq_o}, '0);

    // R4: restart after a short return
    rise_en_i = '1;
    line_i[0] = 1'b1; tick(D);
    line_i[0] = 1'b0; tick(1);
    line_i[0] = 1'b1; tick(D);
    check("R4 count restarted, not yet", rise_sts_o[0], 1'b0);
    tick(1);
    check("R4 qualifies after full restart", rise_sts_o[0], 1'b1);

    // R9: independent counters
    clear_all();
    line_i[3] = 1'b0; line_i[4] = 1'b0; tick(2);
    line_i[3] = 1'b1; tick(D - 1);
    check("R9 glitch on line3 dropped", fall_sts_o[3], 1'b0);
    check("R9 line4 unaffected", fall_sts_o[4], 1'b1);

    // R3: zero debounce qualifies on first edge
    debounce_i = '0;
    clear_all();
    line_i[5] = 1'b1; tick(1);
    check("R3 debounce zero", rise_sts_o, 6'b100000);

    // R3: maximum debounce
    debounce_i = '1;
    clear_all();
    line_i[2] = 1'b0; tick(15);
    check("R3 max debounce one short", fall_sts_o[2], 1'b0);
    tick(1);
    check("R3 max debounce qualifies", fall_sts_o[2], 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule